// File: doc/BRIEF.md
# Bit-Serial CRC-8 Packet Error Code Unit

This block computes an 8-bit packet error code over a stream of data bits on a daisy-chained monitor serial bus. Each enabled clock takes one data bit, most significant bit of each byte first, and folds it into an 8-bit CRC register using the generator x^8 + x^2 + x + 1. A start pulse presets the register to the non-zero value 0x41 at the beginning of each packet. Every bit of the covered data must be shifted in, reserved and revision fields included, or the code will not match the far end.

The current register is always visible on a byte-wide output, so a transmitter can send it once the covered bytes are in. A receiver asks for a compare against the code it received. Any mismatch raises a sticky error flag that holds until the next start. A bit counter reports whether a whole number of bytes has been shifted since the last start. Byte framing and the serial physical layer belong to the surrounding logic.

Top module: `pec8_serial`

## Requirements
- R1: After reset, `code_o` is 0x41, `aligned_o` is 1 and `err_o` is 0.
- R2: A cycle with `start_i` high leaves `code_o` at 0x41, `aligned_o` at 1 and `err_o` at 0 from the next cycle on. This happens whatever `bit_vld_i` and `cmp_vld_i` do in that cycle.
- R3: In a cycle with `bit_vld_i` high and `start_i` low, let f = `bit_i` XOR old bit 7. The new register is {old[6:2], old[1] XOR f, old[0] XOR f, f}.
- R4: In a cycle with `bit_vld_i` and `start_i` both low, `code_o` does not change.
- R5: A byte is fed bit 7 first. After a start followed by the eight bits of any byte value, `code_o` equals the CRC of that byte from seed 0x41.
- R6: `aligned_o` is 1 exactly when the number of bits accepted since the last start or reset is a multiple of 8.
- R7: A cycle with `cmp_vld_i` high and `start_i` low compares `cmp_code_i` with `code_o` as it stands in that cycle. If they differ, `err_o` is 1 from the next cycle on.
- R8: Once set, `err_o` stays 1 until a start, even after later compares that match.
- R9: A matching compare does not set `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Reload seed, clear bit count and error |
| bit_vld_i | input | 1 | Accept `bit_i` this cycle |
| bit_i | input | 1 | Serial data bit |
| cmp_vld_i | input | 1 | Compare `cmp_code_i` with current code |
| cmp_code_i | input | 8 | Received packet error code |
| code_o | output | 8 | Current CRC register |
| aligned_o | output | 1 | Whole bytes shifted since start |
| err_o | output | 1 | Sticky mismatch flag |

## Verification
A wrong tap or a wrong feedback bit shows up on `code_o` one cycle after the first data bit that exercises it. Sweeping every byte value from the seed therefore exposes any single-bit fault in the update within one byte. A miscounting bit counter shows on `aligned_o` at the first byte boundary or mid-byte point sampled. A faulty compare or a faulty sticky error path shows on `err_o` the cycle after the compare, or the cycle after a later matching compare.

// File: rtl/pec8_pkg.sv
// Shared constants and types for the serial CRC-8 unit.
// Assumes an 8-bit code with generator x^8+x^2+x+1 (taps 0x07) and seed 0x41.
package pec8_pkg;
    localparam int          CODE_W       = 8;
    localparam logic [7:0]  DEF_SEED     = 8'h41;
    localparam logic [7:0]  DEF_POLY     = 8'h07;
    localparam int          BITS_PER_BYTE = 8;

    typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/pec8_shift.sv
// CRC register with per-bit update.
// Feedback is the data bit XOR the top bit. Bit 0 takes the feedback.
// Each higher bit takes its lower neighbour, XORed with the feedback where POLY has a 1.
// Assumes POLY[0] is 1, as for any proper generator.
module pec8_shift #(
    parameter int              W    = 8,
    parameter logic [W-1:0]    SEED = 8'h41,
    parameter logic [W-1:0]    POLY = 8'h07
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] code_o
);
    logic         fb;
    logic [W-1:0] nxt;

    // Feedback bit for the incoming data bit.
    assign fb = bit_i ^ code_o[W-1];

    // Bit 0 is always the feedback.
    assign nxt[0] = fb;

    // Next-state bits 1..W-1: shift left, tap where the polynomial is set.
    for (genvar i = 1; i < W; i++) begin : g_bit
        if (POLY[i]) begin : g_tap
            assign nxt[i] = code_o[i-1] ^ fb;
        end else begin : g_pass
            assign nxt[i] = code_o[i-1];
        end
    end

    // Register update: seed on reset or load, step on shift, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) begin
            code_o <= SEED;
        end else if (shift_i) begin
            code_o <= nxt;
        end
    end
endmodule

// File: rtl/pec8_bitcnt.sv
// Modulo-N bit counter.
// Reports when the count of accepted bits is a whole number of bytes.
// Assumes N is at least 2.
module pec8_bitcnt #(
    parameter int N = 8,
    localparam int CW = $clog2(N)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic aligned_o
);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    logic [CW-1:0] cnt;

    // Count bits modulo N; clear on reset or start.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt <= '0;
        end else if (inc_i) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    // Byte boundary indication.
    assign aligned_o = (cnt == '0);
endmodule

// File: rtl/pec8_cmp.sv
// Sticky compare of the current code against a received code.
// The error sets on any mismatched compare and clears only on reset or start.
module pec8_cmp #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         cmp_vld_i,
    input  logic [W-1:0] code_i,
    input  logic [W-1:0] ref_i,
    output logic         err_o
);
    logic miss;

    // Mismatch of the requested compare in this cycle.
    assign miss = cmp_vld_i && (code_i != ref_i);

    // Sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            err_o <= 1'b0;
        end else if (miss) begin
            err_o <= 1'b1;
        end
    end
endmodule

// File: rtl/pec8_serial.sv
// Top of the bit-serial CRC-8 generator and checker.
// Start has priority over shift and compare in the same cycle.
// A compare sees the code as it stands before any shift in the same cycle.
module pec8_serial
    import pec8_pkg::*;
#(
    parameter logic [CODE_W-1:0] SEED  = DEF_SEED,
    parameter logic [CODE_W-1:0] POLY  = DEF_POLY,
    parameter int                NBITS = BITS_PER_BYTE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              bit_vld_i,
    input  logic              bit_i,
    input  logic              cmp_vld_i,
    input  logic [CODE_W-1:0] cmp_code_i,
    output logic [CODE_W-1:0] code_o,
    output logic              aligned_o,
    output logic              err_o
);
    code_t code_q;

    pec8_shift #(.W(CODE_W), .SEED(SEED), .POLY(POLY)) shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (start_i),
        .shift_i (bit_vld_i),
        .bit_i   (bit_i),
        .code_o  (code_q)
    );

    pec8_bitcnt #(.N(NBITS)) cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (start_i),
        .inc_i     (bit_vld_i),
        .aligned_o (aligned_o)
    );

    pec8_cmp #(.W(CODE_W)) cmp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (start_i),
        .cmp_vld_i (cmp_vld_i),
        .code_i    (code_q),
        .ref_i     (cmp_code_i),
        .err_o     (err_o)
    );

    assign code_o = code_q;
endmodule

// File: rtl/pec8_serial_chk.sv
// Checker for pec8_serial, observing ports only.
module pec8_serial_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       bit_vld_i,
    input logic       bit_i,
    input logic       cmp_vld_i,
    input logic [7:0] cmp_code_i,
    input logic [7:0] code_o,
    input logic       aligned_o,
    input logic       err_o
);
    AST_START_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (code_o == 8'h41) && aligned_o && !err_o); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !bit_vld_i) |=> $stable(code_o)); // R4

    AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && bit_vld_i) |=> (code_o[7:3] == $past(code_o[6:2]))); // R3

    AST_FB_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && bit_vld_i) |=> (code_o[0] == ($past(bit_i) ^ $past(code_o[7])))); // R3

    AST_ALIGN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !bit_vld_i) |=> $stable(aligned_o)); // R6

    AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && cmp_vld_i && (cmp_code_i != code_o)) |=> err_o); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !start_i) |=> err_o); // R8

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $past(cmp_vld_i)); // R9
endmodule

bind pec8_serial pec8_serial_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .bit_vld_i  (bit_vld_i),
    .bit_i      (bit_i),
    .cmp_vld_i  (cmp_vld_i),
    .cmp_code_i (cmp_code_i),
    .code_o     (code_o),
    .aligned_o  (aligned_o),
    .err_o      (err_o)
);

// File: tb/pec8_serial_tb_top.sv
`timescale 1ns/100ps
// Bench: sweeps every byte value from the seed, plus multi-byte packets and compares.
module pec8_serial_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       bit_vld_i = 1'b0;
    logic       bit_i = 1'b0;
    logic       cmp_vld_i = 1'b0;
    logic [7:0] cmp_code_i = '0;
    logic [7:0] code_o;
    logic       aligned_o;
    logic       err_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    pec8_serial dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .bit_vld_i(bit_vld_i),
        .bit_i(bit_i), .cmp_vld_i(cmp_vld_i), .cmp_code_i(cmp_code_i),
        .code_o(code_o), .aligned_o(aligned_o), .err_o(err_o)
    );

    always #2.5 clk = ~clk;

    // Arithmetic model: shift left, fold in 0x07 when the outgoing bit differs from data.
    function automatic logic [7:0] model_bit(input logic [7:0] c, input logic d);
        int v;
        v = int'(c) * 2;
        if ((v / 256) % 2 != int'(d)) v = v ^ 32'h107;
        return 8'(v % 256);
    endfunction

    function automatic logic [7:0] model_byte(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r = c;
        for (int k = 7; k >= 0; k--) r = model_bit(r, b[k]);
        return r;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock; inputs change and outputs are read 1 ns after the edge.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        start_i = 0; bit_vld_i = 0; cmp_vld_i = 0;
    endtask

    task automatic do_start();
        idle(); start_i = 1; step(); idle();
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int k = 7; k >= 0; k--) begin
            bit_vld_i = 1; bit_i = b[k]; step();
        end
        bit_vld_i = 0;
    endtask

    task automatic compare(input logic [7:0] c);
        cmp_vld_i = 1; cmp_code_i = c; step(); cmp_vld_i = 0;
    endtask

    initial begin
        logic [7:0] exp;
        logic [7:0] hold;
        repeat (3) step();
        chk("R1 code", code_o, 8'h41);
        chk("R1 aligned", aligned_o, 1);
        chk("R1 err", err_o, 0);
        rst_n = 1;
        step();

        // R5 / R6: every byte value from the seed.
        for (int b = 0; b < 256; b++) begin
            do_start();
            send_byte(8'(b));
            chk("R5 byte crc", code_o, model_byte(8'h41, 8'(b)));
            chk("R6 aligned at byte end", aligned_o, 1);
        end

        // R3: single bit updates from varied states.
        do_start();
        exp = 8'h41;
        for (int k = 0; k < 40; k++) begin
            bit_vld_i = 1; bit_i = logic'((k * 7 + k / 3) % 2); step();
            exp = model_bit(exp, logic'((k * 7 + k / 3) % 2));
            chk("R3 bit step", code_o, exp);
            chk("R6 aligned count", aligned_o, ((k + 1) % 8 == 0) ? 1 : 0);
        end
        bit_vld_i = 0;

        // R4: idle cycles hold the code and the count.
        do_start();
        send_byte(8'hA5);
        send_byte(8'h3C);
        bit_vld_i = 1; bit_i = 1; step(); bit_vld_i = 0;
        hold = code_o;
        repeat (5) step();
        chk("R4 hold", code_o, hold);
        chk("R6 mid-byte not aligned", aligned_o, 0);

        // R2: start beats a bit and a failing compare in the same cycle.
        start_i = 1; bit_vld_i = 1; bit_i = 1; cmp_vld_i = 1; cmp_code_i = 8'h00;
        step(); idle();
        chk("R2 seed", code_o, 8'h41);
        chk("R2 aligned", aligned_o, 1);
        chk("R2 err", err_o, 0);

        // Multi-byte packet: matching compare, then mismatch, then sticky.
        do_start();
        exp = 8'h41;
        for (int j = 0; j < 3; j++) begin
            send_byte(8'(8'h81 + j * 8'h17));
            exp = model_byte(exp, 8'(8'h81 + j * 8'h17));
        end
        chk("R5 packet crc", code_o, exp);
        compare(exp);
        chk("R9 match no err", err_o, 0);
        compare(exp ^ 8'h10);
        chk("R7 mismatch err", err_o, 1);
        compare(exp);
        chk("R8 sticky after match", err_o, 1);
        send_byte(8'h00);
        chk("R8 sticky after bits", err_o, 1);
        do_start();
        chk("R2 start clears err", err_o, 0);

        // R7: compare sees pre-shift code when a bit arrives in the same cycle.
        send_byte(8'h5A);
        exp = code_o;
        bit_vld_i = 1; bit_i = 0; cmp_vld_i = 1; cmp_code_i = exp; step(); idle();
        chk("R7 same-cycle pre-shift compare", err_o, 0);
        chk("R3 shift beside compare", code_o, model_bit(exp, 1'b0));

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule